// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block takes the 48-bit destination address of each received Ethernet frame and decides whether the frame is kept or discarded. Several rules apply, and they are checked in a fixed priority order. First come two override controls: a debug pass-everything bit and a promiscuous bit. Next, the broadcast address is always kept. Group (multicast) addresses are then kept either unconditionally or through a 64-bin hash table. Individual (unicast) addresses must match one entry of a programmable bank of exact-match slots.

The multicast hash index is a 6-bit value computed inside the block. It comes from a CRC-32 that runs over the address over several clock cycles. The number of address bits processed per cycle is a parameter, so the engine can be bit-serial or wider. When a new address is strobed in, the block stops taking input until its decision is out. The decision is registered and appears as a one-cycle pulse, together with a code that names the rule which settled the outcome.

The mode controls and the two hash words are level inputs, driven by registers held elsewhere. They are sampled on the clock edge that produces the decision. The exact-match slots are held inside the block and are loaded through a simple write port.

Top module: `eth_daddr_filter`

## Requirements
- R1: After reset, `dec_valid` is 0, `da_ready` is 1, and every exact-match slot is inactive, so a unicast address with all controls clear is dropped.
- R2: When `ctl_rx_all` is 1, every address is accepted with rule code 1, whatever the other controls are.
- R3: When `ctl_promisc` is 1 and `ctl_rx_all` is 0, every address is accepted with rule code 2.
- R4: With both override controls clear, the address FF:FF:FF:FF:FF:FF is accepted with rule code 3.
- R5: An address is a group address when bit 0 of its first-transmitted byte is 1 (`da_addr[0]`; byte k is `da_addr[8k+7:8k]` and is sent least-significant bit first). When `ctl_pass_mcast` is 1, a non-broadcast group address is accepted with rule code 4. This control has no effect on unicast addresses.
- R6: With `ctl_pass_mcast` clear and `ctl_hash_en` set, a group address is processed as follows. A reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) runs over the 48 bits in transmit order. The result is inverted and then bit-reversed, and its top 6 bits form the index. Index bit 5 picks `hash_hi` (1) or `hash_lo` (0), and index bits 4:0 pick the bit within that word. The frame is accepted with rule code 5 if that bit is 1, and dropped with code 0 otherwise.
- R7: A non-broadcast group address is dropped with rule code 0 when neither `ctl_pass_mcast` nor `ctl_hash_en` is set.
- R8: A unicast address that equals the stored address of an active slot is accepted with rule code 6. A write with `uc_wr_en` high loads `uc_wr_addr` into slot `uc_wr_slot` and sets that slot's active flag to `uc_wr_active`. Every slot from 0 up to SLOTS-1 takes part, and SLOTS is 16 or 32.
- R9: A unicast address that matches no active slot is dropped with rule code 0, and every drop reports rule code 0.
- R10: An address is taken when `da_valid` and `da_ready` are both 1 at a clock edge. `da_ready` then stays 0 until the decision is out. Strobes made while `da_ready` is 0 are ignored. `dec_valid` is a one-cycle pulse that rises 48/CRC_BITS + 1 clock edges after the taking edge.
- R11: When several rules apply, the order from highest to lowest is: receive-all, promiscuous, broadcast, pass-all-multicast, hash, exact match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, first-transmitted byte in bits 7:0 |
| da_ready | output | 1 | High when a new address can be taken |
| ctl_rx_all | input | 1 | Pass every frame (debug) |
| ctl_promisc | input | 1 | Promiscuous mode |
| ctl_pass_mcast | input | 1 | Pass all group addresses |
| ctl_hash_en | input | 1 | Enable hash filtering of group addresses |
| hash_lo | input | 32 | Hash table bins 0 to 31 |
| hash_hi | input | 32 | Hash table bins 32 to 63 |
| uc_wr_en | input | 1 | Exact-match slot write strobe |
| uc_wr_slot | input | $clog2(SLOTS) | Slot written |
| uc_wr_addr | input | 48 | Address stored in the slot |
| uc_wr_active | input | 1 | Active flag stored in the slot |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |
| dec_rule | output | 3 | Rule code: 0 drop, 1 rx-all, 2 promisc, 3 broadcast, 4 pass-mcast, 5 hash, 6 exact |

## Verification
The bench computes the hash index of many group addresses with its own CRC model. It programs only the selected bin, and then every bin except that one. A design that got the CRC bit order, the inversion or the reversal wrong would accept and drop the wrong addresses, and one that swapped the high and low word would fail for about half of the addresses. Exact-match slots are checked at slot 0 and at the last slot, and again after a slot is deactivated. A bank with an off-by-one loop bound or an ignored active flag would give a wrong verdict there. Overlapping rules are stacked on purpose to catch wrong priority. Strobes held high during a busy window check that no second decision and no change of address occur, and every decision is timed against the stated latency.

// File: rtl/daf_pkg.sv
package daf_pkg;
   localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
   localparam int          ADDR_W   = 48;

   typedef enum logic [2:0] {
      RULE_DROP    = 3'd0,
      RULE_RXALL   = 3'd1,
      RULE_PROMISC = 3'd2,
      RULE_BCAST   = 3'd3,
      RULE_MCALL   = 3'd4,
      RULE_HASH    = 3'd5,
      RULE_EXACT   = 3'd6
   } rule_e;
endpackage

// File: rtl/daf_crc_step.sv
module daf_crc_step #(
   parameter int BITS = 8
) (
   input  logic [31:0]     crc_in,
   input  logic [BITS-1:0] data,
   output logic [31:0]     crc_out
);
   import daf_pkg::*;

   generate
      if (BITS == 1) begin : g_serial
         always_comb begin
            crc_out = {1'b0, crc_in[31:1]} ^ ((crc_in[0] ^ data[0]) ? CRC_POLY : 32'h0);
         end
      end else begin : g_wide
         always_comb begin
            logic [31:0] c;
            c = crc_in;
            for (int i = 0; i < BITS; i++) begin
               c = {1'b0, c[31:1]} ^ ((c[0] ^ data[i]) ? CRC_POLY : 32'h0);
            end
            crc_out = c;
         end
      end
   endgenerate
endmodule

// File: rtl/daf_exact_bank.sv
module daf_exact_bank #(
   parameter int SLOTS  = 16,
   parameter int ADDR_W = 48,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_slot,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_active,
   input  logic [ADDR_W-1:0] cmp_addr,
   output logic              hit
);
   logic [SLOTS-1:0] slot_hit;

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         logic [ADDR_W-1:0] addr_q;
         logic              act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q <= '0;
               act_q  <= 1'b0;
            end else if (wr_en && (wr_slot == IDX_W'(s))) begin
               addr_q <= wr_addr;
               act_q  <= wr_active;
            end
         end
         assign slot_hit[s] = act_q && (addr_q == cmp_addr);
      end
   endgenerate

   assign hit = |slot_hit;
endmodule

// File: rtl/daf_decide.sv
module daf_decide (
   input  logic [47:0]         addr,
   input  logic [31:0]         crc,
   input  logic [31:0]         hash_lo,
   input  logic [31:0]         hash_hi,
   input  logic                exact_hit,
   input  logic                rx_all,
   input  logic                promisc,
   input  logic                pass_mcast,
   input  logic                hash_en,
   output logic                accept,
   output daf_pkg::rule_e      rule
);
   import daf_pkg::*;

   logic [5:0] idx;
   logic       bin;
   logic       is_group;
   logic       is_bcast;

   always_comb begin
      for (int k = 0; k < 6; k++) idx[5-k] = ~crc[k];
   end

   assign bin      = idx[5] ? hash_hi[idx[4:0]] : hash_lo[idx[4:0]];
   assign is_group = addr[0];
   assign is_bcast = &addr;

   always_comb begin
      rule = RULE_DROP;
      if (rx_all)                        rule = RULE_RXALL;
      else if (promisc)                  rule = RULE_PROMISC;
      else if (is_bcast)                 rule = RULE_BCAST;
      else if (is_group) begin
         if (pass_mcast)                 rule = RULE_MCALL;
         else if (hash_en && bin)        rule = RULE_HASH;
      end else if (exact_hit)            rule = RULE_EXACT;
      accept = (rule != RULE_DROP);
   end
endmodule

// File: rtl/eth_daddr_filter.sv
module eth_daddr_filter #(
   parameter int SLOTS    = 16,
   parameter int CRC_BITS = 8,
   localparam int IDX_W   = $clog2(SLOTS),
   localparam int STEPS   = 48 / CRC_BITS,
   localparam int CNT_W   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             da_valid,
   input  logic [47:0]      da_addr,
   output logic             da_ready,
   input  logic             ctl_rx_all,
   input  logic             ctl_promisc,
   input  logic             ctl_pass_mcast,
   input  logic             ctl_hash_en,
   input  logic [31:0]      hash_lo,
   input  logic [31:0]      hash_hi,
   input  logic             uc_wr_en,
   input  logic [IDX_W-1:0] uc_wr_slot,
   input  logic [47:0]      uc_wr_addr,
   input  logic             uc_wr_active,
   output logic             dec_valid,
   output logic             dec_accept,
   output logic [2:0]       dec_rule
);
   import daf_pkg::*;

   generate
      if (!(SLOTS == 16 || SLOTS == 32)) begin : g_bad_slots
         $error("SLOTS must be 16 or 32");
      end
      if ((CRC_BITS < 1) || (48 % CRC_BITS != 0)) begin : g_bad_bits
         $error("CRC_BITS must divide 48");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DEC} st_e;

   st_e               st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [47:0]       addr_q;
   logic [47:0]       sh_q;
   logic [31:0]       crc_q;
   logic [31:0]       crc_nxt;
   logic              exact_hit;
   logic              acc_c;
   rule_e             rule_c;

   assign da_ready = (st_q == ST_IDLE);

   daf_crc_step #(.BITS(CRC_BITS)) u_crc (
      .crc_in (crc_q),
      .data   (sh_q[CRC_BITS-1:0]),
      .crc_out(crc_nxt)
   );

   daf_exact_bank #(.SLOTS(SLOTS), .ADDR_W(48)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (uc_wr_en),
      .wr_slot  (uc_wr_slot),
      .wr_addr  (uc_wr_addr),
      .wr_active(uc_wr_active),
      .cmp_addr (addr_q),
      .hit      (exact_hit)
   );

   daf_decide u_dec (
      .addr      (addr_q),
      .crc       (crc_q),
      .hash_lo   (hash_lo),
      .hash_hi   (hash_hi),
      .exact_hit (exact_hit),
      .rx_all    (ctl_rx_all),
      .promisc   (ctl_promisc),
      .pass_mcast(ctl_pass_mcast),
      .hash_en   (ctl_hash_en),
      .accept    (acc_c),
      .rule      (rule_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cnt_q      <= '0;
         addr_q     <= '0;
         sh_q       <= '0;
         crc_q      <= CRC_SEED;
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_rule   <= 3'd0;
      end else begin
         dec_valid <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (da_valid) begin
                  addr_q <= da_addr;
                  sh_q   <= da_addr;
                  crc_q  <= CRC_SEED;
                  cnt_q  <= '0;
                  st_q   <= ST_RUN;
               end
            end
            ST_RUN: begin
               crc_q <= crc_nxt;
               sh_q  <= sh_q >> CRC_BITS;
               if (cnt_q == CNT_W'(STEPS - 1)) st_q <= ST_DEC;
               else cnt_q <= cnt_q + 1'b1;
            end
            ST_DEC: begin
               dec_valid  <= 1'b1;
               dec_accept <= acc_c;
               dec_rule   <= rule_c;
               st_q       <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
   parameter int STEPS = 6
) (
   input logic       clk,
   input logic       rst_n,
   input logic       da_valid,
   input logic       da_ready,
   input logic       ctl_rx_all,
   input logic       ctl_promisc,
   input logic       dec_valid,
   input logic       dec_accept,
   input logic [2:0] dec_rule
);
   logic [7:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= 8'd0;
      else if (da_valid && da_ready) lat_q <= 8'd1;
      else if (dec_valid) lat_q <= 8'd0;
      else if (lat_q != 8'd0) lat_q <= lat_q + 8'd1;
   end

   assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (lat_q == 8'(STEPS + 2)));

   assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && da_ready) |=> !da_ready);

   assert_drop_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (dec_accept == (dec_rule != 3'd0)));

   assert_rx_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(ctl_rx_all)) |-> (dec_accept && dec_rule == 3'd1));

   assert_promisc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(ctl_promisc) && !$past(ctl_rx_all)) |-> (dec_accept && dec_rule == 3'd2));
endmodule

bind eth_daddr_filter daf_checker #(.STEPS(48 / CRC_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .da_valid   (da_valid),
   .da_ready   (da_ready),
   .ctl_rx_all (ctl_rx_all),
   .ctl_promisc(ctl_promisc),
   .dec_valid  (dec_valid),
   .dec_accept (dec_accept),
   .dec_rule   (dec_rule)
);

// File: tb/eth_daddr_filter_tb.sv
module eth_daddr_filter_tb;
   localparam int SLOTS    = 16;
   localparam int CRC_BITS = 8;
   localparam int STEPS    = 48 / CRC_BITS;
   localparam int IDX_W    = $clog2(SLOTS);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             da_valid = 1'b0;
   logic [47:0]      da_addr = '0;
   logic             da_ready;
   logic             ctl_rx_all = 1'b0, ctl_promisc = 1'b0, ctl_pass_mcast = 1'b0, ctl_hash_en = 1'b0;
   logic [31:0]      hash_lo = '0, hash_hi = '0;
   logic             uc_wr_en = 1'b0;
   logic [IDX_W-1:0] uc_wr_slot = '0;
   logic [47:0]      uc_wr_addr = '0;
   logic             uc_wr_active = 1'b0;
   logic             dec_valid, dec_accept;
   logic [2:0]       dec_rule;

   eth_daddr_filter #(.SLOTS(SLOTS), .CRC_BITS(CRC_BITS)) u_dut (.*);

   always #5 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   int last_dec_cyc = 0;
   int dec_count = 0;
   bit finished = 1'b0;

   typedef struct { logic acc; logic [2:0] rule; string req; } exp_t;
   exp_t sb[$];

   logic [47:0] slot_a [SLOTS];
   logic        slot_v [SLOTS];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every decision pulse
   always @(negedge clk) begin
      if (rst_n && dec_valid) begin
         last_dec_cyc = cyc;
         dec_count++;
         if (sb.size() == 0) begin
            check(1'b0, "R10", "unexpected decision", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(dec_accept == e.acc, e.req, "accept", int'(dec_accept), int'(e.acc));
            check(dec_rule == e.rule, e.req, "rule", int'(dec_rule), int'(e.rule));
         end
      end
   end

   function automatic logic [5:0] hash_idx(input logic [47:0] a);
      logic [31:0] c;
      logic [31:0] r;
      logic [31:0] rev;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB8_8320;
         else c = c >> 1;
      end
      r = ~c;
      for (int i = 0; i < 32; i++) rev[i] = r[31-i];
      return rev[31:26];
   endfunction

   function automatic logic [3:0] model(input logic [47:0] a);
      logic [5:0] ix;
      logic       bin;
      logic       hit;
      ix  = hash_idx(a);
      bin = ix[5] ? hash_hi[ix[4:0]] : hash_lo[ix[4:0]];
      hit = 1'b0;
      for (int s = 0; s < SLOTS; s++) if (slot_v[s] && slot_a[s] == a) hit = 1'b1;
      if (ctl_rx_all) return {1'b1, 3'd1};
      if (ctl_promisc) return {1'b1, 3'd2};
      if (a == 48'hFFFF_FFFF_FFFF) return {1'b1, 3'd3};
      if (a[0]) begin
         if (ctl_pass_mcast) return {1'b1, 3'd4};
         if (ctl_hash_en && bin) return {1'b1, 3'd5};
         return {1'b0, 3'd0};
      end
      if (hit) return {1'b1, 3'd6};
      return {1'b0, 3'd0};
   endfunction

   task automatic write_slot(input int s, input logic [47:0] a, input logic act);
      @(negedge clk);
      uc_wr_en = 1'b1; uc_wr_slot = IDX_W'(s); uc_wr_addr = a; uc_wr_active = act;
      @(negedge clk);
      uc_wr_en = 1'b0;
      slot_a[s] = a; slot_v[s] = act;
   endtask

   // driver: pushes the expected item, strobes, optionally keeps strobing during busy
   task automatic send(input logic [47:0] a, input string req, input int busy_strobes = 0);
      exp_t e;
      logic [3:0] m;
      int c0;
      while (!da_ready) @(negedge clk);
      m = model(a);
      e.acc = m[3]; e.rule = m[2:0]; e.req = req;
      sb.push_back(e);
      da_valid = 1'b1; da_addr = a;
      @(negedge clk);
      c0 = cyc;
      if (busy_strobes > 0) begin
         da_addr = ~a;
         repeat (busy_strobes) @(negedge clk);
      end
      da_valid = 1'b0;
      while (sb.size() != 0) begin
         @(negedge clk); #1;
      end
      check(last_dec_cyc - c0 == STEPS + 1, "R10", "latency", last_dec_cyc - c0, STEPS + 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [47:0] ua, ub, uc, mc;
      int seen_hi, seen_lo;
      for (int s = 0; s < SLOTS; s++) begin slot_a[s] = '0; slot_v[s] = 1'b0; end
      ua = 48'h5544_3322_1100; ub = 48'hA0B0_C0D0_E002; uc = 48'h0123_4567_89AA;
      mc = 48'h0100_005E_0001;

      repeat (3) @(negedge clk);
      check(dec_valid == 1'b0, "R1", "dec_valid after reset", int'(dec_valid), 0);
      check(da_ready == 1'b1, "R1", "da_ready after reset", int'(da_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);

      send(48'h0, "R1");
      send(ua, "R1");

      write_slot(0, ua, 1'b1);
      write_slot(SLOTS - 1, ub, 1'b1);
      send(ua, "R8");
      send(ub, "R8");
      send(uc, "R9");
      write_slot(0, ua, 1'b0);
      send(ua, "R8");

      send(48'hFFFF_FFFF_FFFF, "R4");
      send(mc, "R7");
      send(48'h3300_0000_0001 | 48'h1, "R7");

      ctl_pass_mcast = 1'b1;
      send(mc, "R5");
      send(uc, "R5");
      send(ub, "R5");
      ctl_pass_mcast = 1'b0;

      ctl_hash_en = 1'b1;
      seen_hi = 0; seen_lo = 0;
      for (int k = 0; k < 12; k++) begin
         logic [47:0] g;
         logic [5:0]  ix;
         g  = {8'(k * 37), 8'(k + 3), 8'h5E, 8'(k * 11), 8'h00, 8'h01 | 8'(k << 1)};
         ix = hash_idx(g);
         if (ix[5]) seen_hi++; else seen_lo++;
         hash_hi = '0; hash_lo = '0;
         if (ix[5]) hash_hi[ix[4:0]] = 1'b1; else hash_lo[ix[4:0]] = 1'b1;
         send(g, "R6");
         hash_hi = '1; hash_lo = '1;
         if (ix[5]) hash_hi[ix[4:0]] = 1'b0; else hash_lo[ix[4:0]] = 1'b0;
         send(g, "R6");
      end
      check(seen_hi > 0 && seen_lo > 0, "R6", "both words exercised", seen_hi, seen_lo);

      hash_hi = '0; hash_lo = '0;
      ctl_pass_mcast = 1'b1;
      send(mc, "R11");
      ctl_pass_mcast = 1'b0;
      hash_hi = '1; hash_lo = '1;
      send(48'hFFFF_FFFF_FFFF, "R11");
      ctl_hash_en = 1'b0;
      hash_hi = '0; hash_lo = '0;

      ctl_promisc = 1'b1;
      send(uc, "R3");
      send(48'hFFFF_FFFF_FFFF, "R11");
      send(ub, "R11");
      ctl_rx_all = 1'b1;
      send(uc, "R2");
      send(mc, "R2");
      ctl_promisc = 1'b0;
      send(48'h0, "R2");
      ctl_rx_all = 1'b0;

      dec_count = 0;
      send(ub, "R10", 4);
      repeat (STEPS + 4) @(negedge clk);
      check(dec_count == 1, "R10", "decisions for busy strobes", dec_count, 1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule